// File: doc/BRIEF.md
# Preemptive Interrupt Priority Controller

This block chooses among a group of request lines from peripherals or software. Each line has its own enable bit and priority level. The block tells the processor whether any enabled, pending line has a higher priority than the service routine that is running now. A current-level register holds the level of that running routine. When the processor acknowledges the interrupt, the block saves the current level on an internal stack and raises the current level to that of the winning line. An end-of-service strobe removes the top stack entry and writes it back as the current level. Nested service therefore unwinds in last-in, first-out order.

The stack has one entry for each priority level. Software cannot read its entries directly. It sees them only by ending service, which loads each saved level into the current-level register in turn. Two sticky flags in a status register record errors. One is set when an entry is pushed onto a full stack. This can happen after software lowers the current level below that of the running routine. The other is set when an end-of-service arrives with nothing on the stack. Level 0 never interrupts.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, the current level is 0, both status flags are 0 and the stack is empty.
- R2: `irq_o` asserts only if an enabled, pending line has a level strictly greater than the current level. A line at a level equal to or below the current level does not assert it.
- R3: When several qualifying lines share the highest level, `irq_src_o` reports the lowest-numbered one.
- R4: A line whose enable bit is 0, or whose level is 0, takes no part in arbitration.
- R5: `irq_o` and `irq_src_o` are registered. They reflect the requests, configuration and current level present at the previous rising edge. A request removed before acknowledge drops `irq_o` after one edge.
- R6: If `ack_i` is high while `irq_o` is high, the current level is pushed onto the stack and the current level becomes the winner's level. `irq_o` is 0 in the following cycle. If `ack_i` is high while `irq_o` is low, it has no effect.
- R7: `eoi_i` with a non-empty stack pops the most recently saved level into the current-level register.
- R8: `eoi_i` with an empty stack sets status bit 0 (underflow) and leaves the current level unchanged, even if a current-level write arrives in the same cycle.
- R9: The stack holds exactly 2^PRIO_W entries. A push onto a full stack sets status bit 1 (overflow) and discards the pushed entry. The current level is still raised.
- R10: An accepted acknowledge and an `eoi_i` with a non-empty stack in the same cycle leave the stack contents unchanged. The current level becomes the winner's level.
- R11: Register map:
  - Address i (where i < N_SRC): bit PRIO_W is the enable, bits [PRIO_W-1:0] are the level.
  - Address N_SRC: the current level (read/write).
  - Address N_SRC+1: status. Bit 0 is underflow and bit 1 is overflow. Writing 1 to a bit clears it. A new event in the same cycle wins over the clear.
  - Acknowledge and end-of-service take precedence over a current-level write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_SRC | Request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | $clog2(N_SRC+2) | Register address |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data (combinational) |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End of service |
| irq_o | output | 1 | Interrupt to processor |
| irq_src_o | output | max(1,$clog2(N_SRC)) | Winning line index |

## Verification
The two events that can share a cycle are an accepted acknowledge and an end-of-service. The bench drives both strobes on the same clock, so that one nested routine ends just as a higher request is taken. It then judges the result: the current level must be the new level, the next end-of-service must return the level saved before the nesting, and the end-of-service after that must flag underflow. A second overlap is an end-of-service on an empty stack together with a current-level write. The checker watches this case, and the bench covers it by showing that the level survives an empty end-of-service.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;

  localparam int unsigned STAT_UNF_BIT = 0;
  localparam int unsigned STAT_OVF_BIT = 1;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/prio_cfg_regs.sv
module prio_cfg_regs #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_SRC-1:0]             wr_en_i,
  input  logic [PRIO_W:0]              wdata_i,
  output logic [N_SRC-1:0]             en_o,
  output logic [N_SRC-1:0][PRIO_W-1:0] lvl_o
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[g]  <= 1'b0;
        lvl_o[g] <= '0;
      end else if (wr_en_i[g]) begin
        en_o[g]  <= wdata_i[PRIO_W];
        lvl_o[g] <= wdata_i[PRIO_W-1:0];
      end
    end
  end

endmodule

// File: rtl/prio_arb.sv
module prio_arb
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned SRC_W = idx_w(N_SRC)
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0]             en_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] lvl_i,
  output logic                         win_vld_o,
  output logic [SRC_W-1:0]             win_id_o,
  output logic [PRIO_W-1:0]            win_lvl_o
);

  // strict '>' while scanning upward keeps the lowest index on ties; level 0 never wins
  always_comb begin
    win_lvl_o = '0;
    win_id_o  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && en_i[i] && (lvl_i[i] > win_lvl_o)) begin
        win_lvl_o = lvl_i[i];
        win_id_o  = SRC_W'(i);
      end
    end
    win_vld_o = (win_lvl_o != '0);
  end

endmodule

// File: rtl/prio_lifo.sv
module prio_lifo
  import prio_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  input  logic [DW-1:0] push_data_i,
  output logic [DW-1:0] top_o,
  output logic          empty_o,
  output logic          ovf_o
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = idx_w(DEPTH);

  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [CW-1:0]            cnt_q;
  logic                     full;
  logic [IW-1:0]            top_idx;
  logic [IW-1:0]            wr_idx;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign wr_idx  = IW'(cnt_q);
  assign top_o   = empty_o ? '0 : mem_q[top_idx];
  assign ovf_o   = (op_i == STK_PUSH) && full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        STK_PUSH: if (!full) begin
          mem_q[wr_idx] <= push_data_i;
          cnt_q         <= cnt_q + CW'(1);
        end
        STK_POP: if (!empty_o) cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned REG_W  = 8,
  localparam int unsigned AW    = $clog2(N_SRC + 2),
  localparam int unsigned SRC_W = idx_w(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_req_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [SRC_W-1:0] irq_src_o
);

  localparam int unsigned NUM_LVL  = 1 << PRIO_W;
  localparam logic [AW-1:0] ADDR_CUR  = AW'(N_SRC);
  localparam logic [AW-1:0] ADDR_STAT = AW'(N_SRC + 1);

  logic [N_SRC-1:0]             cfg_we;
  logic [N_SRC-1:0]             cfg_en;
  logic [N_SRC-1:0][PRIO_W-1:0] cfg_lvl;
  logic                         win_vld;
  logic [SRC_W-1:0]             win_id;
  logic [PRIO_W-1:0]            win_lvl;

  logic [PRIO_W-1:0] cur_q, cur_d;
  logic [PRIO_W-1:0] lvl_q;
  logic [SRC_W-1:0]  src_q;
  logic              irq_q;
  logic              ovf_q, unf_q;

  logic              ack_ok, pop_ok, unf_evt, ovf_evt;
  logic              cur_we, stat_we;
  stk_op_e           stk_op;
  logic [PRIO_W-1:0] stk_top;
  logic              stk_empty;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[REG_W-1:PRIO_W+1];

  for (genvar g = 0; g < N_SRC; g++) begin : g_dec
    assign cfg_we[g] = reg_we_i && (reg_addr_i == AW'(g));
  end
  assign cur_we  = reg_we_i && (reg_addr_i == ADDR_CUR);
  assign stat_we = reg_we_i && (reg_addr_i == ADDR_STAT);

  prio_cfg_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_we),
    .wdata_i (reg_wdata_i[PRIO_W:0]),
    .en_o    (cfg_en),
    .lvl_o   (cfg_lvl)
  );

  prio_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i     (irq_req_i),
    .en_i      (cfg_en),
    .lvl_i     (cfg_lvl),
    .win_vld_o (win_vld),
    .win_id_o  (win_id),
    .win_lvl_o (win_lvl)
  );

  assign ack_ok  = ack_i && irq_q;
  assign pop_ok  = eoi_i && !stk_empty;
  assign unf_evt = eoi_i && stk_empty;

  // ack and pop together: the ending routine's saved level stays as the new one's
  always_comb begin
    if (ack_ok && !pop_ok)      stk_op = STK_PUSH;
    else if (pop_ok && !ack_ok) stk_op = STK_POP;
    else                        stk_op = STK_HOLD;
  end

  prio_lifo #(.DEPTH(NUM_LVL), .DW(PRIO_W)) u_lifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (stk_op),
    .push_data_i (cur_q),
    .top_o       (stk_top),
    .empty_o     (stk_empty),
    .ovf_o       (ovf_evt)
  );

  always_comb begin
    cur_d = cur_q;
    if (ack_ok)                cur_d = lvl_q;
    else if (pop_ok)           cur_d = stk_top;
    else if (cur_we && !eoi_i) cur_d = reg_wdata_i[PRIO_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      irq_q <= 1'b0;
      lvl_q <= '0;
      src_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      irq_q <= !ack_ok && win_vld && (win_lvl > cur_q);
      lvl_q <= win_lvl;
      src_q <= win_id;
      ovf_q <= (ovf_q && !(stat_we && reg_wdata_i[STAT_OVF_BIT])) || ovf_evt;
      unf_q <= (unf_q && !(stat_we && reg_wdata_i[STAT_UNF_BIT])) || unf_evt;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (reg_addr_i == AW'(i)) reg_rdata_o = REG_W'({cfg_en[i], cfg_lvl[i]});
    end
    if (reg_addr_i == ADDR_CUR) reg_rdata_o = REG_W'(cur_q);
    if (reg_addr_i == ADDR_STAT) begin
      reg_rdata_o[STAT_UNF_BIT] = unf_q;
      reg_rdata_o[STAT_OVF_BIT] = ovf_q;
    end
  end

  assign irq_o     = irq_q;
  assign irq_src_o = src_q;

endmodule

// File: rtl/prio_irq_sva.sv
module prio_irq_sva #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned AW     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              eoi_i,
  input logic              irq_o,
  input logic              reg_we_i,
  input logic [AW-1:0]     reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [PRIO_W-1:0] cur_q,
  input logic [PRIO_W-1:0] lvl_q,
  input logic [PRIO_W-1:0] stk_top,
  input logic              stk_empty,
  input logic              ovf_q,
  input logic              unf_q
);

  logic acc;
  logic ovf_clr;
  assign acc     = ack_i && irq_o;
  assign ovf_clr = reg_we_i && (reg_addr_i == AW'(N_SRC + 1)) && reg_wdata_i[1];

  p_above_cur_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (lvl_q > $past(cur_q)));

  p_lvl0_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (lvl_q != '0));

  p_ack_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !irq_o);

  p_ack_raise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (cur_q == $past(lvl_q)));

  p_pop_restore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !stk_empty && !acc) |=> (cur_q == $past(stk_top)));

  p_unf_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && stk_empty && !acc) |=> (unf_q && $stable(cur_q)));

  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);

  p_merge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && eoi_i && !stk_empty) |=> ((cur_q == $past(lvl_q)) && (stk_top == $past(stk_top))));

endmodule

bind prio_irq_ctrl prio_irq_sva #(
  .N_SRC (N_SRC),
  .PRIO_W(PRIO_W),
  .REG_W (REG_W),
  .AW    (AW)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_i       (ack_i),
  .eoi_i       (eoi_i),
  .irq_o       (irq_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cur_q       (cur_q),
  .lvl_q       (lvl_q),
  .stk_top     (stk_top),
  .stk_empty   (stk_empty),
  .ovf_q       (ovf_q),
  .unf_q       (unf_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;

  localparam int NS = 4;
  localparam int PW = 2;
  localparam int RW = 8;
  localparam int AW = $clog2(NS + 2);
  localparam int A_CUR  = NS;
  localparam int A_STAT = NS + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rdata;
  logic          ack = 1'b0;
  logic          eoi = 1'b0;
  logic          irq;
  logic [1:0]    src;

  int n_chk = 0;
  int n_err = 0;

  always #5ns clk = ~clk;

  prio_irq_ctrl #(.N_SRC(NS), .PRIO_W(PW), .REG_W(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .irq_src_o(src)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr = AW'(a); wdata = RW'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = AW'(a);
    #1ns;
    v = int'(rdata);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1; @(negedge clk); eoi = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    rd(A_CUR, v);  chk("R1 cur", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    pulse_eoi();
    rd(A_STAT, v); chk("R1 empty stack", v, 1);
    wr(A_STAT, 1);

    // R11 config: src0 L1, src1 L2, src2 L3, src3 L3 disabled; enable at bit PW
    wr(0, 4 | 1); wr(1, 4 | 2); wr(2, 4 | 3); wr(3, 3);
    rd(0, v); chk("R11 cfg0", v, 5);
    rd(3, v); chk("R11 cfg3", v, 3);
    wr(A_CUR, 2); rd(A_CUR, v); chk("R11 cur rw", v, 2);
    wr(A_CUR, 0);

    // R5 one-edge latency, dropped request
    req = 4'b0001; @(negedge clk);
    chk("R5 rise", int'(irq), 1); chk("R5 src", int'(src), 0);
    req = 4'b0000; @(negedge clk);
    chk("R5 drop", int'(irq), 0);

    // R4 disabled line ignored
    req = 4'b1000; @(negedge clk); @(negedge clk);
    chk("R4 disabled", int'(irq), 0);

    // R6 acknowledge
    req = 4'b0001; @(negedge clk);
    chk("R6 pre", int'(irq), 1);
    pulse_ack();
    chk("R6 irq low", int'(irq), 0);
    rd(A_CUR, v); chk("R6 cur", v, 1);
    @(negedge clk);
    chk("R2 equal no preempt", int'(irq), 0);
    pulse_ack();
    rd(A_CUR, v); chk("R6 ignored ack", v, 1);

    // R7 nesting and pop order
    req = 4'b0011; @(negedge clk);
    chk("R7 irq1", int'(irq), 1); chk("R7 src1", int'(src), 1);
    pulse_ack();
    req = 4'b0111; @(negedge clk);
    chk("R7 src2", int'(src), 2);
    pulse_ack();
    rd(A_CUR, v); chk("R7 cur3", v, 3);
    req = '0;
    pulse_eoi(); rd(A_CUR, v); chk("R7 pop2", v, 2);
    pulse_eoi(); rd(A_CUR, v); chk("R7 pop1", v, 1);
    pulse_eoi(); rd(A_CUR, v); chk("R7 pop0", v, 0);

    // R8 underflow keeps level
    wr(A_CUR, 2);
    pulse_eoi();
    rd(A_CUR, v);  chk("R8 cur kept", v, 2);
    rd(A_STAT, v); chk("R8 unf", v, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v); chk("R11 w1c", v, 0);
    wr(A_CUR, 0);

    // R9 overflow: depth 4
    req = 4'b0001;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 irq", int'(irq), 1);
      pulse_ack();
      rd(A_CUR, v); chk("R9 cur", v, 1);
      rd(A_STAT, v); chk("R9 ovf", v, (k == 4) ? 2 : 0);
      if (k < 4) wr(A_CUR, 0);
    end
    req = '0;
    for (int k = 0; k < 4; k++) begin
      pulse_eoi(); rd(A_CUR, v); chk("R9 pop", v, 0);
    end
    rd(A_STAT, v); chk("R9 four kept", v, 2);
    pulse_eoi();
    rd(A_STAT, v); chk("R9 then unf", v, 3);
    wr(A_STAT, 3);

    // R10 ack and eoi in one cycle
    req = 4'b0001; @(negedge clk);
    pulse_ack();
    req = 4'b0010; @(negedge clk);
    chk("R10 irq", int'(irq), 1); chk("R10 src", int'(src), 1);
    ack = 1'b1; eoi = 1'b1; @(negedge clk); ack = 1'b0; eoi = 1'b0;
    rd(A_CUR, v); chk("R10 cur", v, 2);
    req = '0;
    pulse_eoi();
    rd(A_CUR, v);  chk("R10 restore", v, 0);
    rd(A_STAT, v); chk("R10 no unf", v, 0);
    pulse_eoi();
    rd(A_STAT, v); chk("R10 depth one", v, 1);
    wr(A_STAT, 3);

    // R2/R3/R4 sweep over levels, enables, requests and current level
    for (int seed = 0; seed < 256; seed++) begin
      int lv[NS];
      int en;
      en = (seed % 3 == 0) ? 15 : ((seed ^ (seed >> 4)) & 15);
      for (int i = 0; i < NS; i++) begin
        lv[i] = (seed >> (2 * i)) & 3;
        wr(i, (((en >> i) & 1) << PW) | lv[i]);
      end
      for (int c = 0; c < 4; c++) begin
        for (int m = 0; m < 16; m++) begin
          int best, bid;
          best = 0; bid = 0;
          for (int i = 0; i < NS; i++)
            if (((m >> i) & 1) && ((en >> i) & 1) && lv[i] > best) begin
              best = lv[i]; bid = i;
            end
          req = NS'(m);
          wr(A_CUR, c);
          @(negedge clk);
          chk("R2/R4 sweep irq", int'(irq), (best > c) ? 1 : 0);
          if (best > c) chk("R3 sweep src", int'(src), bid);
        end
      end
    end

    summary();
  end

endmodule